// File: doc/BRIEF.md
# Saturating Transmit Statistics Counter Register

This block keeps transmit statistics for an Ethernet MAC. It holds four small counters, packed side by side into one 16-bit read-only register. The transmit engine sends one completion report per packet. The report carries four items: the number of collisions the packet met, a deferral flag, an excessive-deferral flag and a success flag. The block sorts each report and advances at most one step in each matching counter.

The counters stop at their top value instead of rolling over. A host reads the register with a single-cycle read strobe. The read returns the packed counters and clears all four counters together. An interrupt level stays high while any counter sits at its top value. This lets a host keep statistics with no per-packet interrupt, by reading the register from time to time.

Top module: `txstat_counter_reg`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x0000, `irq` is low and all four counters are zero.
- R2: The single-collision field, bits [3:0], advances by one for a report with `rpt_success` high and exactly one collision. A report with one collision and `rpt_success` low leaves it unchanged.
- R3: The multiple-collision field, bits [7:4], advances by one for a report whose collision count lies in 2..16, whatever the success flag. Counts of 0 and of 17 or more leave both collision fields unchanged.
- R4: The deferred field, bits [11:8], advances by one for a report with `rpt_deferred` high.
- R5: The excessively-deferred field, bits [15:12], advances by one for a report with `rpt_exc_deferred` high.
- R6: A field at 15 (0xF) stays at 15 when further matching reports arrive. It never wraps to 0.
- R7: `irq` is high in the cycle after any field reaches 15. It stays high while any field is 15 and goes low in the cycle after the read that clears the counters.
- R8: A `rd_strobe` pulse causes `rd_data`, one cycle later, to show the counters as they stood before that edge. The same edge clears all four fields. `rd_data` holds its value until the next read.
- R9: When a read and a report come in the same cycle, the read returns the old value. Each cleared field then holds exactly that report's increment, either 0 or 1.
- R10: A single report raises each field by at most one, even when it matches several categories at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | One-cycle packet completion report |
| rpt_coll | input | 5 | Collisions seen by the reported packet |
| rpt_deferred | input | 1 | Packet was deferred at least once |
| rpt_exc_deferred | input | 1 | Packet was excessively deferred |
| rpt_success | input | 1 | Packet was transmitted successfully |
| rd_strobe | input | 1 | Register read request, one cycle |
| rd_data | output | 16 | Packed counters captured by the last read |
| irq | output | 1 | High while any counter is at 15 |

## Verification
The assertions check the following on every cycle:
- the reset values;
- the fields that stay pinned at 15 while no read happens;
- a field never rising by more than one per cycle;
- the read capture returning the pre-edge counters;
- fields of at most one after a read;
- `irq` agreeing with the counters.

Some behaviours show only in the bench's scenarios. These are the sorting of each report into the correct field, including the collision-count limits 0, 1, 16 and 17. The bench also covers single collision without success, a combined report, a long run into saturation, and a read that meets a report in the same cycle.

// File: rtl/txstat_pkg.sv
`timescale 1ns/1ps
package txstat_pkg;
  localparam int NUM_FIELDS = 4;
  // Field slot order inside the packed register, lowest nibble first
  localparam int F_SINGLE = 0;
  localparam int F_MULTI  = 1;
  localparam int F_DEFER  = 2;
  localparam int F_EXCDEF = 3;
endpackage

// File: rtl/txstat_classify.sv
`timescale 1ns/1ps
module txstat_classify
  import txstat_pkg::*;
#(
  parameter int COLL_W    = 5,
  parameter int MULTI_MIN = 2,
  parameter int MULTI_MAX = 16
) (
  input  logic                  rpt_valid,
  input  logic [COLL_W-1:0]     rpt_coll,
  input  logic                  rpt_deferred,
  input  logic                  rpt_exc_deferred,
  input  logic                  rpt_success,
  output logic [NUM_FIELDS-1:0] bump
);
  int coll_i;

  always_comb begin
    coll_i = int'(rpt_coll);
    bump   = '0;
    if (rpt_valid) begin
      // R2: exactly one collision, and the packet got through
      bump[F_SINGLE] = rpt_success && (coll_i == 1);
      // R3: collision count inside the multi window
      bump[F_MULTI]  = (coll_i >= MULTI_MIN) && (coll_i <= MULTI_MAX);
      // R4, R5: one step per packet, however many deferrals it saw
      bump[F_DEFER]  = rpt_deferred;
      bump[F_EXCDEF] = rpt_exc_deferred;
    end
  end
endmodule

// File: rtl/txstat_satcnt.sv
`timescale 1ns/1ps
module txstat_satcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         bump,
  output logic [W-1:0] q,
  output logic         full_next
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] nxt;
  logic [W-1:0] step;

  always_comb begin
    step = {{(W-1){1'b0}}, bump};
    if (clr)
      nxt = step;               // R9: the cleared value takes this cycle's event
    else if (q == TOP)
      nxt = q;                  // R6: hold at the top value
    else
      nxt = q + step;
    full_next = (nxt == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/txstat_counter_reg.sv
`timescale 1ns/1ps
module txstat_counter_reg
  import txstat_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int COLL_W    = 5,
  parameter int MULTI_MAX = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rpt_valid,
  input  logic [COLL_W-1:0]            rpt_coll,
  input  logic                         rpt_deferred,
  input  logic                         rpt_exc_deferred,
  input  logic                         rpt_success,
  input  logic                         rd_strobe,
  output logic [NUM_FIELDS*CNT_W-1:0]  rd_data,
  output logic                         irq
);
  localparam int DATA_W = NUM_FIELDS * CNT_W;

  logic [NUM_FIELDS-1:0] bump;
  logic [NUM_FIELDS-1:0] full_nxt;
  logic [DATA_W-1:0]     cnt_flat;

  txstat_classify #(
    .COLL_W(COLL_W), .MULTI_MIN(2), .MULTI_MAX(MULTI_MAX)
  ) u_cls (
    .rpt_valid(rpt_valid), .rpt_coll(rpt_coll), .rpt_deferred(rpt_deferred),
    .rpt_exc_deferred(rpt_exc_deferred), .rpt_success(rpt_success), .bump(bump)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cnt
    txstat_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(rd_strobe), .bump(bump[i]),
      .q(cnt_flat[i*CNT_W +: CNT_W]), .full_next(full_nxt[i])
    );
  end

  // R8: the read captures the pre-edge counters and holds them.
  // R7: irq is registered from next-state, so it tracks the counters.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (rd_strobe) rd_data <= cnt_flat;
      irq <= |full_nxt;
    end
  end
endmodule

// File: rtl/txstat_counter_reg_chk.sv
`timescale 1ns/1ps
module txstat_counter_reg_chk
  import txstat_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_strobe,
  input logic [NUM_FIELDS*CNT_W-1:0] rd_data,
  input logic                        irq,
  input logic [NUM_FIELDS*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic any_top;
  always_comb begin
    any_top = 1'b0;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (cnt_flat[i*CNT_W +: CNT_W] == TOP) any_top = 1'b1;
  end

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && !irq && cnt_flat == '0));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == any_top);

  a_r8_read_capture: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_data == $past(cnt_flat));

  a_r8_read_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (!rd_strobe && cnt_flat[i*CNT_W +: CNT_W] == TOP)
        |=> cnt_flat[i*CNT_W +: CNT_W] == TOP);

    a_r10_one_step: assert property (@(posedge clk) disable iff (rst)
      !rd_strobe |=> (int'(cnt_flat[i*CNT_W +: CNT_W])
                      <= int'($past(cnt_flat[i*CNT_W +: CNT_W])) + 1));

    a_r9_clear_take: assert property (@(posedge clk) disable iff (rst)
      rd_strobe |=> int'(cnt_flat[i*CNT_W +: CNT_W]) <= 1);
  end
endmodule

bind txstat_counter_reg txstat_counter_reg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_data(rd_data),
  .irq(irq), .cnt_flat(cnt_flat)
);

// File: tb/txstat_counter_reg_test.sv
`timescale 1ns/1ps
module txstat_counter_reg_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rpt_valid = 0, rpt_deferred = 0, rpt_exc_deferred = 0, rpt_success = 0;
  logic [4:0]  rpt_coll = '0;
  logic        rd_strobe = 0;
  logic [15:0] rd_data;
  logic        irq;

  int nchk = 0, nfail = 0;
  int m [4];
  logic [15:0] m_rd = '0;
  bit m_irq = 0;

  always #2.5 clk = ~clk;

  txstat_counter_reg uut (
    .clk(clk), .rst(rst), .rpt_valid(rpt_valid), .rpt_coll(rpt_coll),
    .rpt_deferred(rpt_deferred), .rpt_exc_deferred(rpt_exc_deferred),
    .rpt_success(rpt_success), .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [15:0] pack();
    return {m[3][3:0], m[2][3:0], m[1][3:0], m[0][3:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a negedge, model the posedge, compare at the following negedge.
  task automatic step(input bit rd, input bit v, input int coll, input bit d,
                      input bit e, input bit s, input string tag);
    int inc [4];
    rd_strobe = rd; rpt_valid = v; rpt_coll = 5'(coll);
    rpt_deferred = d; rpt_exc_deferred = e; rpt_success = s;
    inc[0] = (v && s && coll == 1) ? 1 : 0;
    inc[1] = (v && coll >= 2 && coll <= 16) ? 1 : 0;
    inc[2] = (v && d) ? 1 : 0;
    inc[3] = (v && e) ? 1 : 0;
    @(posedge clk);
    if (rd) m_rd = pack();
    for (int i = 0; i < 4; i++) begin
      if (rd) m[i] = inc[i];
      else if (m[i] + inc[i] > 15) m[i] = 15;
      else m[i] = m[i] + inc[i];
    end
    m_irq = (m[0] == 15 || m[1] == 15 || m[2] == 15 || m[3] == 15);
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, m_rd);
    check({tag, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    rd_strobe = 0; rpt_valid = 0; rpt_coll = '0;
    rpt_deferred = 0; rpt_exc_deferred = 0; rpt_success = 0;
  endtask

  task automatic rd(input string tag);
    step(1, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset rd_data", rd_data, 16'h0000);
    check("R1 reset irq", {15'd0, irq}, 16'h0000);
    rd("R1 read after reset");

    step(0, 1, 1, 0, 0, 1, "R2 single ok");
    step(0, 1, 1, 0, 0, 0, "R2 one coll no success");
    rd("R2 read single");

    step(0, 1, 2, 0, 0, 1, "R3 two coll");
    step(0, 1, 16, 0, 0, 0, "R3 sixteen coll");
    step(0, 1, 0, 0, 0, 1, "R3 zero coll");
    step(0, 1, 17, 0, 0, 1, "R3 seventeen coll");
    step(0, 1, 31, 0, 0, 0, "R3 max coll");
    rd("R3 read multi");

    step(0, 1, 0, 1, 0, 1, "R4 deferred");
    step(0, 1, 0, 0, 1, 0, "R5 exc deferred");
    step(0, 0, 1, 1, 1, 1, "R10 invalid report ignored");
    rd("R4 R5 read deferral");

    step(0, 1, 3, 1, 1, 1, "R10 combined");
    rd("R10 read combined");

    for (int k = 0; k < 17; k++) step(0, 1, 1, 1, 0, 1, "R6 R7 saturate");
    step(0, 0, 0, 0, 0, 0, "R7 irq held");
    rd("R6 read saturated");
    step(0, 0, 0, 0, 0, 0, "R7 irq dropped");

    for (int k = 0; k < 15; k++) step(0, 1, 5, 0, 1, 0, "R9 fill");
    step(1, 1, 5, 0, 1, 0, "R9 read with report");
    rd("R9 read leftover");
    rd("R8 read empty");
    step(0, 0, 0, 0, 0, 0, "R8 hold");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule